// File: doc/BRIEF.md
# Rate-Selectable Integrate-and-Dump Decimator

This block turns the one-bit output stream of a delta-sigma modulator into signed conversion results. It applies a single-stage boxcar (sinc1) filter: over one output window it counts how many ones and how many zeros arrive, takes the difference, and dumps that sum as one result. A modulator-rate enable marks the clock cycles that carry a valid modulator bit, so the block can run from a system clock faster than the modulator.

A two-bit rate code selects both the window length and the output resolution. Longer windows give slower output rates and more bits. The raw sum is scaled to the target width and saturated to that width's signed range. It is then sign-extended to 16 bits, so codes from every rate can be summed in one 16-bit accumulator.

A run input powers the filter up and down. Each rising edge of run opens a fresh window, and a one-cycle done strobe marks every new result.

Top module: `sinc1_decim`

## Requirements
- R1: While reset is asserted and after it is released, `done` is 0 and `result` is 0x0000 until the first window completes.
- R2: A window holds 2^L accepted samples, with L = 10, 12, 13 and 14 for rate codes 0, 1, 2 and 3. `done` is high in the clock cycle right after the edge that accepts the window's last sample.
- R3: The raw sum is (ones − zeros) over the window. It is scaled by 2^(W−1−L) (an arithmetic shift), where W is the resolution for the window's rate code.
- R4: The resolution W is 12, 14, 15 and 16 bits for rate codes 0, 1, 2 and 3. The scaled value is clipped to [−2^(W−1), 2^(W−1)−1], so a full-scale positive input reads 0x07FF, 0x1FFF, 0x3FFF and 0x7FFF.
- R5: `result` is two's complement, right-justified and sign-extended to 16 bits. A 12-bit minimum code reads 0xF800, a 14-bit minimum reads 0xE000, and a 16-bit minimum reads 0x8000.
- R6: A cycle with `mod_en` low accepts no sample: its `mod_bit` has no effect on the sum or on the window count.
- R7: While `run` is low, no `done` is produced, `result` holds its last value, and any partly filled window is discarded.
- R8: A rising edge on `run` clears the sum and the sample count, so the first result afterwards covers exactly one full new window.
- R9: `done` lasts exactly one clock cycle, and `result` changes only in a cycle where `done` is high.
- R10: The rate code is sampled in the cycle `run` rises and in the cycle a window's last sample is accepted. A change in the middle of a window takes effect from the next window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | High to convert; a rising edge starts a fresh window |
| mod_en | input | 1 | Marks a cycle that carries a valid modulator bit |
| mod_bit | input | 1 | One-bit modulator output (1 counts +1, 0 counts −1) |
| rate_sel | input | 2 | Rate code selecting window length and resolution |
| done | output | 1 | One-cycle strobe marking a new result |
| result | output | 16 | Sign-extended two's-complement conversion result |

## Verification
A wrong sample count shows up as a `done` strobe one or more accepted samples early or late, so every window checks the exact cycle of the strobe. A wrong sum shows up only at the window boundary, in the value latched into `result`. Full-scale inputs therefore catch scaling and clipping errors within one window, and a mixed pattern catches errors in the sum itself. A stale count or sum left over from before power-down leaves the first window after a restart short or offset, and that is visible as an early strobe or a wrong code.

// File: rtl/sinc1_pkg.sv
package sinc1_pkg;
    localparam int NUM_RATES = 4;
    localparam int OUT_W     = 16;

    typedef logic [1:0]       rate_t;
    typedef logic [OUT_W-1:0] code_t;
endpackage

// File: rtl/sinc1_scale_clip.sv
module sinc1_scale_clip
    import sinc1_pkg::*;
#(
    parameter int WIN_LOG2 = 10,
    parameter int RES_W    = 12,
    parameter int SUM_W    = 16
) (
    input  logic signed [SUM_W-1:0] sum,
    output code_t                   code
);
    localparam int SHIFT = WIN_LOG2 + 1 - RES_W;
    localparam int SH_R  = (SHIFT >= 0) ? SHIFT : 0;
    localparam int SH_L  = (SHIFT < 0) ? -SHIFT : 0;
    localparam logic signed [31:0] MAX_C = (32'sd1 <<< (RES_W - 1)) - 32'sd1;
    localparam logic signed [31:0] MIN_C = -(32'sd1 <<< (RES_W - 1));

    logic signed [31:0] wide;
    logic signed [31:0] scaled;
    logic signed [31:0] clipped;

    always_comb begin
        wide   = 32'(sum);
        scaled = (wide >>> SH_R) <<< SH_L;
        if (scaled > MAX_C)
            clipped = MAX_C;
        else if (scaled < MIN_C)
            clipped = MIN_C;
        else
            clipped = scaled;
        code = clipped[OUT_W-1:0];
    end
endmodule

// File: rtl/sinc1_win_sel.sv
module sinc1_win_sel
    import sinc1_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  rate_t            rate,
    input  logic [CNT_W-1:0] last_tab [NUM_RATES],
    input  code_t            code_tab [NUM_RATES],
    output logic [CNT_W-1:0] last_cnt,
    output code_t            code
);
    always_comb begin
        last_cnt = last_tab[rate];
        code     = code_tab[rate];
    end
endmodule

// File: rtl/sinc1_decim.sv
module sinc1_decim
    import sinc1_pkg::*;
#(
    parameter int unsigned WIN_LOG2 [NUM_RATES] = '{10, 12, 13, 14},
    parameter int unsigned RES_BITS [NUM_RATES] = '{12, 14, 15, 16}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic        mod_en,
    input  logic        mod_bit,
    input  logic [1:0]  rate_sel,
    output logic        done,
    output logic [15:0] result
);
    function automatic int widest_window();
        int m = 1;
        for (int i = 0; i < NUM_RATES; i++)
            if (int'(WIN_LOG2[i]) > m) m = int'(WIN_LOG2[i]);
        return m;
    endfunction

    localparam int CNT_W = widest_window();
    localparam int SUM_W = CNT_W + 2;

    typedef struct packed {
        logic                    run;
        rate_t                   rate;
        logic signed [SUM_W-1:0] acc;
        logic [CNT_W-1:0]        cnt;
        code_t                   res;
        logic                    done;
    } state_t;

    state_t st_d, st_q;

    logic                    start;
    rate_t                   rate_eff;
    logic signed [SUM_W-1:0] step;
    logic signed [SUM_W-1:0] acc_base;
    logic [CNT_W-1:0]        cnt_base;
    logic signed [SUM_W-1:0] sum_now;
    logic [CNT_W-1:0]        last_tab [NUM_RATES];
    code_t                   code_tab [NUM_RATES];
    logic [CNT_W-1:0]        last_cnt;
    code_t                   code_sel;
    logic                    win_end;

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
        assign last_tab[g] = CNT_W'((32'd1 << WIN_LOG2[g]) - 32'd1);
        sinc1_scale_clip #(
            .WIN_LOG2 (int'(WIN_LOG2[g])),
            .RES_W    (int'(RES_BITS[g])),
            .SUM_W    (SUM_W)
        ) u_scale (
            .sum  (sum_now),
            .code (code_tab[g])
        );
    end

    sinc1_win_sel #(.CNT_W(CNT_W)) u_sel (
        .rate     (rate_eff),
        .last_tab (last_tab),
        .code_tab (code_tab),
        .last_cnt (last_cnt),
        .code     (code_sel)
    );

    always_comb begin
        start    = run && !st_q.run;
        rate_eff = start ? rate_t'(rate_sel) : st_q.rate;
        step     = {{(SUM_W-1){~mod_bit}}, 1'b1};
        acc_base = start ? '0 : st_q.acc;
        cnt_base = start ? '0 : st_q.cnt;
        sum_now  = acc_base + step;
        win_end  = mod_en && (cnt_base == last_cnt);

        st_d      = st_q;
        st_d.run  = run;
        st_d.done = 1'b0;
        if (!run) begin
            st_d.acc = '0;
            st_d.cnt = '0;
        end else begin
            st_d.rate = rate_eff;
            st_d.acc  = acc_base;
            st_d.cnt  = cnt_base;
            if (win_end) begin
                st_d.acc  = '0;
                st_d.cnt  = '0;
                st_d.res  = code_sel;
                st_d.done = 1'b1;
                st_d.rate = rate_t'(rate_sel);
            end else if (mod_en) begin
                st_d.acc = sum_now;
                st_d.cnt = cnt_base + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    logic                    armed_q;
    logic signed [SUM_W-1:0] acc_q;

    assign done    = st_q.done;
    assign result  = st_q.res;
    assign armed_q = st_q.run;
    assign acc_q   = st_q.acc;
endmodule

module sinc1_decim_chk #(
    parameter int SUM_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    run,
    input logic                    mod_en,
    input logic                    done,
    input logic [15:0]             result,
    input logic                    armed_q,
    input logic signed [SUM_W-1:0] acc_q
);
    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !done);

    a_r6_no_sample_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (run && armed_q && !mod_en) |=> $stable(acc_q));

    a_r7_sum_cleared_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (acc_q == '0));
endmodule

bind sinc1_decim sinc1_decim_chk #(.SUM_W(SUM_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .mod_en  (mod_en),
    .done    (done),
    .result  (result),
    .armed_q (armed_q),
    .acc_q   (acc_q)
);

// File: tb/sinc1_decim_tb.sv
`timescale 1ns/1ps
module sinc1_decim_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        mod_en = 1'b0;
    logic        mod_bit = 1'b0;
    logic [1:0]  rate_sel = 2'd0;
    logic        done;
    logic [15:0] result;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    localparam int L_TAB [4] = '{10, 12, 13, 14};
    localparam int W_TAB [4] = '{12, 14, 15, 16};

    always #5 clk = ~clk;

    sinc1_decim u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .mod_en(mod_en),
        .mod_bit(mod_bit), .rate_sel(rate_sel), .done(done), .result(result)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_code(input int sum, input int rate);
        int l = L_TAB[rate];
        int w = W_TAB[rate];
        int s;
        int mx = (1 << (w - 1)) - 1;
        int mn = -(1 << (w - 1));
        if (w - 1 >= l) s = sum * (1 << (w - 1 - l));
        else            s = sum >>> (l - w + 1);
        if (s > mx) s = mx;
        if (s < mn) s = mn;
        return 16'(s);
    endfunction

    function automatic bit pat_bit(input int kind, input int i);
        case (kind)
            0: return 1'b0;
            1: return 1'b1;
            2: return (i % 4) != 0;
            default: return i[0];
        endcase
    endfunction

    // Feeds n accepted samples; optional idle cycle (mod_en low, inverted bit) before each.
    task automatic feed(input int n, input int kind, input bit gap,
                        output int pulses, output int idx, output logic [15:0] got,
                        output bit unstable);
        logic [15:0] prev;
        pulses = 0; idx = -1; got = result; unstable = 1'b0; prev = result;
        for (int i = 0; i < n; i++) begin
            bit b = pat_bit(kind, i);
            if (gap) begin
                @(negedge clk); mod_en = 1'b0; mod_bit = ~b;
                @(posedge clk); #1;
                if (done) begin pulses++; idx = -2; end
            end
            @(negedge clk); mod_en = 1'b1; mod_bit = b;
            @(posedge clk); #1;
            if (done) begin pulses++; idx = i; got = result; prev = result; end
            else if (result !== prev) unstable = 1'b1;
        end
        @(negedge clk); mod_en = 1'b0;
    endtask

    task automatic restart(input logic [1:0] r);
        @(negedge clk); run = 1'b0; mod_en = 1'b0; rate_sel = r;
        @(negedge clk); run = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic window_check(input string req, input int n, input int kind,
                                input bit gap, input logic [15:0] exp);
        int p, ix; logic [15:0] g; bit u;
        feed(n, kind, gap, p, ix, g, u);
        chk(p == 1, {req, " R9 one done per window"}, p, 1);
        chk(ix == n - 1, {req, " R2 done after last sample"}, ix, n - 1);
        chk(g === exp, {req, " code"}, g, exp);
        chk(!u, {req, " R9 result stable between strobes"}, u, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(done === 1'b0, "R1 done in reset", done, 0);
        chk(result === 16'h0000, "R1 result in reset", result, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk(done === 1'b0 && result === 16'h0000, "R1 after release", result, 0);
    endtask

    task automatic t_rate0_patterns();
        restart(2'd0);
        window_check("R4 12-bit clip high", 1024, 1, 1'b0, 16'h07FF);
        window_check("R5 12-bit min F800", 1024, 0, 1'b0, 16'hF800);
        window_check("R3 three-quarter density", 1024, 2, 1'b0, exp_code(512, 0));
        window_check("R3 half density zero", 1024, 3, 1'b0, 16'h0000);
    endtask

    task automatic t_rate_change();
        int p, ix; logic [15:0] g; bit u;
        restart(2'd0);
        feed(100, 1, 1'b0, p, ix, g, u);
        chk(p == 0, "R10 no early done", p, 0);
        rate_sel = 2'd1;
        feed(924, 1, 1'b0, p, ix, g, u);
        chk(p == 1 && ix == 923, "R10 window keeps start rate length", ix, 923);
        chk(g === 16'h07FF, "R10 window keeps start rate width", g, 16'h07FF);
        window_check("R10 next window at new rate, R5 E000", 4096, 0, 1'b0, 16'hE000);
        window_check("R4 14-bit clip high", 4096, 1, 1'b0, 16'h1FFF);
    endtask

    task automatic t_wide_rates();
        restart(2'd2);
        window_check("R4 15-bit clip high", 8192, 1, 1'b0, 16'h3FFF);
        restart(2'd3);
        window_check("R5 16-bit min 8000", 16384, 0, 1'b0, 16'h8000);
    endtask

    task automatic t_gated();
        restart(2'd0);
        window_check("R6 idle cycles ignored", 1024, 0, 1'b1, 16'hF800);
    endtask

    task automatic t_power_down();
        int p, ix; logic [15:0] g; bit u; int seen;
        logic [15:0] held;
        restart(2'd0);
        window_check("R3 before power-down", 1024, 2, 1'b0, exp_code(512, 0));
        held = result;
        feed(500, 1, 1'b0, p, ix, g, u);
        chk(p == 0, "R8 partial window no done", p, 0);
        @(negedge clk); run = 1'b0;
        seen = 0;
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk); mod_en = 1'b1; mod_bit = 1'b1;
            @(posedge clk); #1;
            if (done) seen++;
        end
        @(negedge clk); mod_en = 1'b0;
        chk(seen == 0, "R7 no done while off", seen, 0);
        chk(result === held, "R7 result held while off", result, held);
        @(negedge clk); run = 1'b1; rate_sel = 2'd0;
        @(posedge clk); #1;
        window_check("R8 fresh window after restart", 1024, 0, 1'b0, 16'hF800);
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog R2 actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_rate0_patterns();
        t_rate_change();
        t_wide_rates();
        t_gated();
        t_power_down();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule